// File: doc/BRIEF.md
# Buffered SPI Master Controller

A register-mapped SPI master that serialises words written by software into a 16-byte transmit queue and collects the words it clocks in into a 16-byte receive queue. The word width is selectable (8, 16 or 32 bits), so each queue holds 16, 8 or 4 words. The serial clock runs at the system clock divided by 2*(divider+1). Clock idle level, launch edge and capture point are all programmable. An optional automatic slave-select keeps the target selected for as long as there is work queued or in flight.

Software uses four registers: control, status, data and clock divider. Every write names one of three actions: replace, clear the given bits, or set the given bits. Writing the data register queues a word for transmission. Reading it removes the oldest received word. Status reports both queue fill levels and a sticky receive-overflow flag.

Top module: `spi_word_master`

## Requirements
- R1: Register index 0 is control, 1 status, 2 data and 3 divider. Write action 0 (and 3) replaces the register, 1 clears the bits set in the write data, and 2 sets them. Control keeps only bits 5, 6, 8, 9, 10, 11, 15 and 28, and the others read as 0.
- R2: The divider register is 9 bits wide. Higher bits that are written are discarded and read back as 0.
- R3: SCLK rests at the level of control bit 6 whenever no word is shifting. Each SCLK half-period lasts divider+1 clock cycles.
- R4: Control bits 11:10 select the word width: 0 gives 8 bits, 1 gives 16 and 2 gives 32. MOSI sends each queued word MSB first, with exactly that many clock pulses per word, and queued words follow one another.
- R5: With control bit 8 set, MOSI changes on active-to-idle SCLK edges. With it clear, MOSI changes on idle-to-active edges. MISO is sampled at the mid-bit edge when control bit 9 is clear, and at the end of the bit when it is set. Each received word enters the receive queue right-justified and is read from the data register.
- R6: Each queue holds 16 bytes: 16, 8 or 4 words by width. A data write to a full transmit queue is dropped. Status bits 20:16 give the transmit fill level and bits 28:24 the receive fill level.
- R7: Shifting happens only when control bit 15 (enable) and bit 5 (master) are both set. While enable is clear, both queues stay empty and data writes are dropped.
- R8: When control bit 28 is set and the block is enabled, ss_n is low while the transmit queue holds a word or a word is shifting, and high otherwise. When bit 28 is clear, ss_n stays high.
- R9: Status bit 6 is set when a word completes while the receive queue is full. That word is lost. The bit stays set until a status write clears it.
- R10: A data read from an empty receive queue has no effect: the fill level stays 0 and later words are received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue for index 2) |
| bus_reg | input | 2 | Register index |
| bus_op | input | 2 | Write action: replace, clear bits, set bits |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_rd |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Automatic slave select, active low |

## Verification
A register write takes effect at the clock edge that accepts it. Shifting starts on the edge after a word is queued. SCLK then toggles every divider+1 cycles, and a received word is counted in status on the edge that ends its last bit. The bench never assumes a fixed latency for whole transfers. It polls the status fill levels until the expected count appears, bounded by a cycle limit. A serial target model follows each SCLK edge to record MOSI and drive MISO. Only the half-period test counts cycles, from one observed SCLK edge to the next, sampled at falling clock edges.

// File: rtl/spi_wm_pkg.sv
package spi_wm_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2,
        REG_DIV  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_REPLACE = 2'd0,
        OP_CLEAR   = 2'd1,
        OP_SET     = 2'd2,
        OP_ALT     = 2'd3
    } wr_op_e;

    localparam int CB_MASTER = 5;
    localparam int CB_CKP    = 6;
    localparam int CB_CKE    = 8;
    localparam int CB_SMP    = 9;
    localparam int CB_WS     = 10;
    localparam int CB_ON     = 15;
    localparam int CB_AUTOSS = 28;

    localparam int SB_OVF = 6;
    localparam int SB_TXL = 16;
    localparam int SB_RXL = 24;

    localparam logic [31:0] CTRL_KEEP =
        (32'd1 << CB_MASTER) | (32'd1 << CB_CKP) | (32'd1 << CB_CKE) |
        (32'd1 << CB_SMP) | (32'd3 << CB_WS) | (32'd1 << CB_ON) |
        (32'd1 << CB_AUTOSS);

    function automatic logic [31:0] apply_op(wr_op_e op, logic [31:0] cur,
                                             logic [31:0] wd);
        case (op)
            OP_CLEAR: return cur & ~wd;
            OP_SET:   return cur | wd;
            default:  return wd;
        endcase
    endfunction

    function automatic logic [5:0] word_bits(logic [1:0] ws);
        case (ws)
            2'd0:    return 6'd8;
            2'd1:    return 6'd16;
            default: return 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/spi_wm_fifo.sv
module spi_wm_fifo #(
    parameter int SLOTS = 16,
    parameter int WIDTH = 32,
    localparam int PW = $clog2(SLOTS),
    localparam int LW = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [LW-1:0]    cap,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [LW-1:0]    level
);
    logic [WIDTH-1:0] mem [SLOTS];
    logic [PW-1:0]    rd_ptr, wr_ptr;
    logic             do_pop, do_push;

    assign do_pop  = pop && (level != '0);
    assign do_push = push && ((level < cap) || do_pop);
    assign dout    = mem[rd_ptr];

    function automatic logic [PW-1:0] next_ptr(logic [PW-1:0] p);
        return (p == PW'(SLOTS - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/spi_wm_shifter.sv
module spi_wm_shifter
    import spi_wm_pkg::*;
#(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             ckp,
    input  logic             cke,
    input  logic             smp,
    input  logic [1:0]       wsize,
    input  logic [DIV_W-1:0] div,
    input  logic             tx_avail,
    input  logic [31:0]      tx_word,
    input  logic             miso,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [31:0]      rx_word,
    output logic             busy,
    output logic             sclk,
    output logic             mosi
);
    logic             busy_q, half_q, cap_q;
    logic [DIV_W-1:0] cnt_q;
    logic [5:0]       bit_q, nbits;
    logic [31:0]      sh_q;
    logic [30:0]      rsh_q;
    logic             tick, bit_end, last, word_end, in_bit;
    logic [31:0]      rx_full, rx_mask, aligned;

    assign nbits    = word_bits(wsize);
    assign tick     = busy_q && (cnt_q == div);
    assign bit_end  = tick && half_q;
    assign last     = (bit_q == nbits - 6'd1);
    assign word_end = bit_end && last;
    assign in_bit   = smp ? miso : cap_q;
    assign rx_full  = {rsh_q, in_bit};
    assign rx_mask  = (nbits == 6'd32) ? '1 : ((32'd1 << nbits) - 32'd1);
    assign rx_word  = rx_full & rx_mask;
    assign aligned  = tx_word << (6'd32 - nbits);

    assign tx_pop  = run && tx_avail && (!busy_q || word_end);
    assign rx_push = run && word_end;
    assign busy    = busy_q;
    // active phase: second half when launching on trailing edges, first half otherwise
    assign sclk    = ckp ^ (busy_q && (half_q == cke));
    assign mosi    = busy_q & sh_q[31];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            half_q <= 1'b0;
            cap_q  <= 1'b0;
            cnt_q  <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            rsh_q  <= '0;
        end else if (!run) begin
            busy_q <= 1'b0;
            half_q <= 1'b0;
            cnt_q  <= '0;
        end else if (tx_pop) begin
            busy_q <= 1'b1;
            half_q <= 1'b0;
            cnt_q  <= '0;
            bit_q  <= '0;
            sh_q   <= aligned;
        end else if (busy_q) begin
            if (tick) begin
                cnt_q <= '0;
                if (!half_q) begin
                    half_q <= 1'b1;
                    cap_q  <= miso;
                end else begin
                    half_q <= 1'b0;
                    rsh_q  <= rx_full[30:0];
                    if (last) begin
                        busy_q <= 1'b0;
                    end else begin
                        bit_q <= bit_q + 6'd1;
                        sh_q  <= {sh_q[30:0], 1'b0};
                    end
                end
            end else begin
                cnt_q <= cnt_q + DIV_W'(1);
            end
        end
    end
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
    import spi_wm_pkg::*;
#(
    parameter int FIFO_BYTES = 16,
    parameter int DIV_W      = 9
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_reg,
    input  logic [1:0]  bus_op,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic        ss_n
);
    localparam int SLOTS = FIFO_BYTES;
    localparam int LVL_W = $clog2(SLOTS + 1);

    logic [31:0]      ctrl_q;
    logic [DIV_W-1:0] div_q;
    logic             ovf_q;

    logic [31:0]      ctrl_nx;
    logic [DIV_W-1:0] div_nx;
    logic             ovf_nx;
    logic [LVL_W-1:0] cap, tx_lvl, rx_lvl;
    logic [31:0]      tx_head, rx_head, rx_word, stat;
    logic             tx_pop, rx_push, busy, ovf_evt, rx_pop;
    logic             wr_ctrl, wr_stat, wr_data, wr_div;
    logic             en, run;
    wr_op_e           op;
    reg_sel_e         sel;

    assign op  = wr_op_e'(bus_op);
    assign sel = reg_sel_e'(bus_reg);

    assign wr_ctrl = bus_wr && (sel == REG_CTRL);
    assign wr_stat = bus_wr && (sel == REG_STAT);
    assign wr_data = bus_wr && (sel == REG_DATA);
    assign wr_div  = bus_wr && (sel == REG_DIV);
    assign rx_pop  = bus_rd && (sel == REG_DATA);

    assign en  = ctrl_q[CB_ON];
    assign run = en && ctrl_q[CB_MASTER];

    always_comb begin
        case (ctrl_q[CB_WS +: 2])
            2'd0:    cap = LVL_W'(SLOTS);
            2'd1:    cap = LVL_W'(SLOTS / 2);
            default: cap = LVL_W'(SLOTS / 4);
        endcase
    end

    spi_wm_fifo #(.SLOTS(SLOTS), .WIDTH(32)) u_txq (
        .clk(clk), .rst(rst), .flush(!en), .cap(cap),
        .push(wr_data), .din(bus_wdata), .pop(tx_pop),
        .dout(tx_head), .level(tx_lvl)
    );

    spi_wm_fifo #(.SLOTS(SLOTS), .WIDTH(32)) u_rxq (
        .clk(clk), .rst(rst), .flush(!en), .cap(cap),
        .push(rx_push), .din(rx_word), .pop(rx_pop),
        .dout(rx_head), .level(rx_lvl)
    );

    spi_wm_shifter #(.DIV_W(DIV_W)) u_shift (
        .clk(clk), .rst(rst), .run(run),
        .ckp(ctrl_q[CB_CKP]), .cke(ctrl_q[CB_CKE]), .smp(ctrl_q[CB_SMP]),
        .wsize(ctrl_q[CB_WS +: 2]), .div(div_q),
        .tx_avail(tx_lvl != '0), .tx_word(tx_head), .miso(miso),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
        .busy(busy), .sclk(sclk), .mosi(mosi)
    );

    assign ovf_evt = rx_push && (rx_lvl >= cap) && !(rx_pop && rx_lvl != '0);
    assign ss_n    = !(en && ctrl_q[CB_AUTOSS] && (busy || tx_lvl != '0));

    always_comb begin
        ctrl_nx = apply_op(op, ctrl_q, bus_wdata) & CTRL_KEEP;
        case (op)
            OP_CLEAR: begin
                div_nx = div_q & ~bus_wdata[DIV_W-1:0];
                ovf_nx = ovf_q & ~bus_wdata[SB_OVF];
            end
            OP_SET: begin
                div_nx = div_q | bus_wdata[DIV_W-1:0];
                ovf_nx = ovf_q | bus_wdata[SB_OVF];
            end
            default: begin
                div_nx = bus_wdata[DIV_W-1:0];
                ovf_nx = bus_wdata[SB_OVF];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            div_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_nx;
            if (wr_div)  div_q  <= div_nx;
            ovf_q <= (wr_stat ? ovf_nx : ovf_q) | ovf_evt;
        end
    end

    always_comb begin
        stat                 = '0;
        stat[SB_OVF]         = ovf_q;
        stat[SB_TXL +: LVL_W] = tx_lvl;
        stat[SB_RXL +: LVL_W] = rx_lvl;
        case (sel)
            REG_CTRL: bus_rdata = ctrl_q;
            REG_STAT: bus_rdata = stat;
            REG_DATA: bus_rdata = rx_head;
            default:  bus_rdata = 32'(div_q);
        endcase
    end
endmodule

// File: rtl/spi_wm_checker.sv
module spi_wm_checker #(
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             master,
    input logic             autoss,
    input logic             ckp,
    input logic             busy,
    input logic             sclk,
    input logic             ss_n,
    input logic             ovf,
    input logic             stat_wr,
    input logic [LVL_W-1:0] cap,
    input logic [LVL_W-1:0] tx_lvl,
    input logic [LVL_W-1:0] rx_lvl
);
    // R8
    ss_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!en || !autoss) |-> ss_n);

    // R6
    tx_within_cap_chk: assert property (@(posedge clk) disable iff (rst)
        en |-> (tx_lvl <= cap));

    // R6
    rx_within_cap_chk: assert property (@(posedge clk) disable iff (rst)
        en |-> (rx_lvl <= cap));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && !stat_wr) |=> ovf);

    // R7
    off_empties_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (tx_lvl == '0 && rx_lvl == '0));

    // R7
    no_shift_chk: assert property (@(posedge clk) disable iff (rst)
        !(en && master) |=> !busy);

    // R3
    sclk_rest_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk == ckp));
endmodule

bind spi_word_master spi_wm_checker #(.LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst(rst),
    .en(ctrl_q[spi_wm_pkg::CB_ON]), .master(ctrl_q[spi_wm_pkg::CB_MASTER]),
    .autoss(ctrl_q[spi_wm_pkg::CB_AUTOSS]), .ckp(ctrl_q[spi_wm_pkg::CB_CKP]),
    .busy(busy), .sclk(sclk), .ss_n(ss_n), .ovf(ovf_q), .stat_wr(wr_stat),
    .cap(cap), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl)
);

// File: tb/test_spi_word_master.sv
`timescale 1ns/1ps
module test_spi_word_master;
    logic        clk = 1'b0, rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_reg = 2'd0, bus_op = 2'd0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        sclk, mosi, ss_n, miso_r = 1'b0;

    int nchk = 0, nfail = 0;
    bit done = 0;

    // target model state
    logic tb_ckp = 1'b0, tb_cke = 1'b1;
    int   si = 0, mo_i = 0;
    logic mo_bits [1024];

    spi_word_master i_spi_word_master (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_reg(bus_reg), .bus_op(bus_op), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi), .miso(miso_r),
        .ss_n(ss_n)
    );

    always #4 clk = ~clk;

    function automatic logic sbit(int i);
        return ((i * 5 + i / 3) % 7) > 2;
    endfunction

    function automatic logic [31:0] txw(int k, int nb);
        logic [31:0] v = 32'hA5C3_0F1E ^ (k * 32'h1357_9BDF);
        return (nb == 32) ? v : (v & ((32'd1 << nb) - 1));
    endfunction

    function automatic logic [31:0] rxw(int k, int nb);
        logic [31:0] v = '0;
        for (int j = 0; j < nb; j++) v = {v[30:0], sbit(k * nb + j)};
        return v;
    endfunction

    // serial target: leading edge = idle-to-active
    always @(sclk) begin
        if (sclk !== tb_ckp) begin
            if (tb_cke) begin
                if (mo_i < 1024) mo_bits[mo_i] = mosi;
                mo_i++;
            end else begin
                miso_r = sbit(si);
                si++;
            end
        end else begin
            if (tb_cke) begin
                si++;
                miso_r = sbit(si);
            end else begin
                if (mo_i < 1024) mo_bits[mo_i] = mosi;
                mo_i++;
            end
        end
    end

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic reg_wr(logic [1:0] r, logic [1:0] op, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_reg = r; bus_op = op; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_rd(logic [1:0] r, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_reg = r;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_rx(int n);
        logic [31:0] s;
        for (int t = 0; t < 20000; t++) begin
            reg_rd(2'd1, s);
            if (int'(s[28:24]) >= n) return;
        end
        chk("R5", "receive level timeout", s[28:24], n);
    endtask

    task automatic setup(int ws, logic ckp, logic cke, logic smp,
                         int dv, logic ass, logic mst);
        reg_wr(2'd0, 2'd0, 32'h0);
        reg_wr(2'd3, 2'd0, dv);
        tb_ckp = ckp; tb_cke = cke;
        reg_wr(2'd0, 2'd0, (32'(mst) << 5) | (32'(ckp) << 6) | (32'(cke) << 8) |
                           (32'(smp) << 9) | (32'(ws) << 10) | (32'(ass) << 28));
        si = 0; mo_i = 0;
        miso_r = cke ? sbit(0) : 1'b0;
        chk("R3", "sclk rests at polarity", sclk, ckp);
        reg_wr(2'd0, 2'd2, 32'h8000);
    endtask

    task automatic xfer(string tag, int ws, logic ckp, logic cke, logic smp,
                        int dv, int n, logic ass);
        int nb = (ws == 0) ? 8 : (ws == 1) ? 16 : 32;
        logic [31:0] d, m;
        setup(ws, ckp, cke, smp, dv, ass, 1'b1);
        for (int k = 0; k < n; k++) reg_wr(2'd2, 2'd0, txw(k, nb));
        chk("R8", {tag, " ss_n during shift"}, ss_n, !ass);
        wait_rx(n);
        repeat (2) @(negedge clk);
        chk("R8", {tag, " ss_n after shift"}, ss_n, 1'b1);
        chk("R4", {tag, " clock pulses"}, mo_i, n * nb);
        for (int k = 0; k < n; k++) begin
            reg_rd(2'd2, d);
            chk("R5", {tag, " received word"}, d, rxw(k, nb));
            m = '0;
            for (int j = 0; j < nb; j++) m = {m[30:0], mo_bits[(k * nb + j) % 1024]};
            chk("R4", {tag, " sent word"}, m, txw(k, nb));
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        reg_rd(2'd0, d); chk("R1", "reset control", d, 0);
        reg_rd(2'd1, d); chk("R6", "reset status", d, 0);
        reg_rd(2'd3, d); chk("R2", "reset divider", d, 0);
        chk("R8", "reset ss_n", ss_n, 1);
        chk("R3", "reset sclk", sclk, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        reg_wr(2'd0, 2'd2, 32'h0000_0020); reg_wr(2'd0, 2'd2, 32'h0000_0040);
        reg_rd(2'd0, d); chk("R1", "set action", d, 32'h60);
        reg_wr(2'd0, 2'd1, 32'h0000_0020);
        reg_rd(2'd0, d); chk("R1", "clear action", d, 32'h40);
        reg_wr(2'd0, 2'd0, 32'hFFFF_FFFF);
        reg_rd(2'd0, d); chk("R1", "replace keeps defined bits", d, 32'h1000_8F60);
        reg_wr(2'd0, 2'd0, 32'h0);
        reg_wr(2'd3, 2'd0, 32'h0000_FFFF);
        reg_rd(2'd3, d); chk("R2", "divider width", d, 32'h1FF);
        reg_wr(2'd3, 2'd1, 32'h0000_0100);
        reg_rd(2'd3, d); chk("R2", "divider clear", d, 32'hFF);
    endtask

    task automatic t_half_period();
        logic [31:0] d;
        int n = 0;
        setup(0, 1'b0, 1'b1, 1'b0, 2, 1'b1, 1'b1);
        reg_wr(2'd2, 2'd0, txw(0, 8));
        for (int t = 0; t < 100 && sclk == 1'b0; t++) @(negedge clk);
        for (int t = 0; t < 100 && sclk == 1'b1; t++) begin @(negedge clk); n++; end
        chk("R3", "half period cycles", n, 3);
        wait_rx(1);
        reg_rd(2'd2, d);
        chk("R5", "word after period test", d, rxw(0, 8));
    endtask

    task automatic t_capacity();
        logic [31:0] s;
        setup(0, 1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b0);
        for (int k = 0; k < 20; k++) reg_wr(2'd2, 2'd0, k);
        repeat (40) @(negedge clk);
        reg_rd(2'd1, s);
        chk("R6", "8-bit capacity", s[20:16], 16);
        chk("R7", "no shift without master", s[28:24], 0);
        chk("R7", "sclk idle without master", {sclk, mosi}, 2'b00);
        setup(1, 1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b0);
        for (int k = 0; k < 12; k++) reg_wr(2'd2, 2'd0, k);
        reg_rd(2'd1, s); chk("R6", "16-bit capacity", s[20:16], 8);
        setup(2, 1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b0);
        for (int k = 0; k < 6; k++) reg_wr(2'd2, 2'd0, k);
        reg_rd(2'd1, s); chk("R6", "32-bit capacity", s[20:16], 4);
        reg_wr(2'd0, 2'd0, 32'h0000_0020);
        reg_wr(2'd2, 2'd0, 32'h55);
        reg_rd(2'd1, s); chk("R7", "disabled drops data and empties", s, 0);
    endtask

    task automatic t_overflow();
        logic [31:0] s, d;
        setup(0, 1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b1);
        for (int k = 0; k < 16; k++) reg_wr(2'd2, 2'd0, txw(k, 8));
        wait_rx(16);
        reg_rd(2'd1, s); chk("R9", "no overflow at full", s[6], 0);
        reg_wr(2'd2, 2'd0, txw(16, 8));
        repeat (40) @(negedge clk);
        reg_rd(2'd1, s);
        chk("R9", "overflow flag", s[6], 1);
        chk("R6", "receive level at full", s[28:24], 16);
        reg_rd(2'd2, d); chk("R9", "oldest word kept", d, rxw(0, 8));
        reg_rd(2'd1, s); chk("R9", "flag sticky after read", s[6], 1);
        reg_wr(2'd1, 2'd1, 32'h40);
        reg_rd(2'd1, s); chk("R9", "flag cleared", s[6], 0);
        for (int k = 1; k < 16; k++) reg_rd(2'd2, d);
        chk("R9", "last kept word", d, rxw(15, 8));
        reg_rd(2'd2, d);
        reg_rd(2'd1, s); chk("R10", "empty read keeps level", s[28:24], 0);
        reg_wr(2'd2, 2'd0, txw(17, 8));
        wait_rx(1);
        reg_rd(2'd2, d); chk("R10", "word after empty read", d, rxw(17, 8));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        xfer("8b mode0 mid", 0, 1'b0, 1'b1, 1'b0, 1, 4, 1'b1);
        xfer("8b mode0 end", 0, 1'b0, 1'b1, 1'b1, 0, 3, 1'b1);
        xfer("16b mode3", 1, 1'b1, 1'b0, 1'b0, 1, 3, 1'b1);
        xfer("16b mode1 end", 1, 1'b0, 1'b0, 1'b1, 2, 2, 1'b1);
        xfer("32b mode2", 2, 1'b1, 1'b1, 1'b0, 0, 4, 1'b1);
        xfer("8b manual ss", 0, 1'b0, 1'b1, 1'b0, 0, 2, 1'b0);
        t_half_period();
        t_capacity();
        t_overflow();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule